// File: doc/BRIEF.md
# Horizontal Microcoded Control Sequencer

This block is the control unit of a multicycle processor, built as a tiny embedded sequencer. A 4-bit micro-address register selects one word of a read-only microcode store. Each word is horizontal. Its eighteen control bits leave the block unchanged as datapath control lines, with no field decoding. A 2-bit sequencing field chooses the following micro-address.

The sequencing field has four choices. The next address can be the current one plus one. It can be the fetch routine at address 0. It can also come from one of two lookup tables indexed by the 6-bit instruction opcode. The first table routes a freshly decoded instruction to its execution routine. The second separates loads from stores after the shared address calculation. An opcode that the selected table does not hold sends the sequencer back to fetch and raises a sticky illegal-opcode flag. Only reset clears the flag. The microcode and both tables are combinational lookups inside the RTL.

Top module: `useq_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the micro-address to 0 and clears the illegal-opcode flag, whatever the sequencer was doing.
- R2: ctrl_o is the control part of the word at the current micro-address. Bit layout is [17] pc_wr, [16] pc_wr_cond, [15] iord, [14] mem_rd, [13] mem_wr, [12] ir_wr, [11] mem_to_reg, [10:9] pc_src, [8:7] alu_op, [6:5] alu_b_sel, [4] alu_a_sel, [3] reg_wr, [2] reg_dst, [1] mdr_wr, [0] aluout_wr. Only these fields are nonzero: 0 pc_wr, mem_rd, ir_wr, alu_b_sel=01. 1 alu_b_sel=11, aluout_wr. 2 alu_a_sel, alu_b_sel=10, aluout_wr. 3 mem_rd, iord, mdr_wr. 4 reg_wr, mem_to_reg. 5 mem_wr, iord. 6 alu_a_sel, alu_op=10, aluout_wr. 7 reg_wr, reg_dst. 8 alu_a_sel, alu_op=01, pc_wr_cond, pc_src=01. 9 pc_wr, pc_src=10.
- R3: Words 0, 3 and 6 carry the increment code (11), so the next micro-address is the current one plus one.
- R4: Words 4, 5, 7, 8 and 9 carry the fetch code (00), so the next micro-address is 0.
- R5: Word 1 selects the first table (code 01). It maps opcode 0x00 to 6, 0x02 to 9, 0x04 to 8, and both 0x23 and 0x2B to 2.
- R6: Word 2 selects the second table (code 10). It maps opcode 0x23 to 3 and 0x2B to 5.
- R7: An opcode missing from the selected table makes the next micro-address 0 and sets illegal_o one cycle later. illegal_o then stays at 1 until reset.
- R8: ir_wr is asserted only at micro-address 0. mem_rd and mem_wr are never asserted together.
- R9: The opcode has no effect on the next micro-address except at the two table-lookup words (1 and 2).
- R10: With a constant legal opcode, the number of cycles from leaving fetch until the next return to address 0 is 4 for 0x00, 5 for 0x23, 4 for 0x2B, 3 for 0x04 and 3 for 0x02.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | 6 | Instruction opcode used by the table lookups |
| ctrl_o | output | 18 | Datapath control lines taken from the current microword |
| uaddr_o | output | 4 | Current micro-address |
| illegal_o | output | 1 | Sticky flag for an opcode missing from a lookup table |

## Verification
A table miss and the sticky flag can act in the same cycle. The miss forces the next micro-address to fetch while the flag latches, and the flag must stay set while later lookups hit. A reset can also arrive on the same edge as a miss. The bench changes the opcode on every cycle, sometimes between the two lookups of one instruction, so that a load's second lookup sees an ALU opcode. It also fires occasional resets at random points. A model computed from the requirements predicts the micro-address, the flag and the control word, and the outputs are compared against it on every cycle.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int UA_W     = 4;
    localparam int OPC_W    = 6;
    localparam int CTRL_W   = 18;
    localparam int N_UWORDS = 1 << UA_W;
    localparam int N_TABLES = 2;

    typedef logic [UA_W-1:0]  uaddr_t;
    typedef logic [OPC_W-1:0] opcode_t;

    // Sequencing codes; values are part of the microword format.
    typedef enum logic [1:0] {
        SEQ_FETCH = 2'b00,
        SEQ_DISP1 = 2'b01,
        SEQ_DISP2 = 2'b10,
        SEQ_NEXT  = 2'b11
    } seq_e;

    // Horizontal control fields, MSB first.
    typedef struct packed {
        logic       pc_wr;
        logic       pc_wr_cond;
        logic       iord;
        logic       mem_rd;
        logic       mem_wr;
        logic       ir_wr;
        logic       mem_to_reg;
        logic [1:0] pc_src;
        logic [1:0] alu_op;
        logic [1:0] alu_b_sel;
        logic       alu_a_sel;
        logic       reg_wr;
        logic       reg_dst;
        logic       mdr_wr;
        logic       aluout_wr;
    } ctrl_t;

    typedef struct packed {
        ctrl_t ctrl;
        seq_e  seq;
    } uword_t;

    typedef struct packed {
        logic   hit;
        uaddr_t target;
    } disp_t;

    localparam opcode_t OPC_ALU = 6'h00;
    localparam opcode_t OPC_JMP = 6'h02;
    localparam opcode_t OPC_BR  = 6'h04;
    localparam opcode_t OPC_LD  = 6'h23;
    localparam opcode_t OPC_ST  = 6'h2B;

    localparam uaddr_t UA_FETCH  = 4'd0;
    localparam uaddr_t UA_DECODE = 4'd1;
    localparam uaddr_t UA_MEMADR = 4'd2;
    localparam uaddr_t UA_LDRD   = 4'd3;
    localparam uaddr_t UA_LDWB   = 4'd4;
    localparam uaddr_t UA_STWR   = 4'd5;
    localparam uaddr_t UA_ALUEX  = 4'd6;
    localparam uaddr_t UA_ALUWB  = 4'd7;
    localparam uaddr_t UA_BR     = 4'd8;
    localparam uaddr_t UA_JMP    = 4'd9;

    // Microprogram contents; unlisted words are blank and return to fetch.
    function automatic uword_t ucode(uaddr_t a);
        uword_t w;
        w = '0;
        w.seq = SEQ_FETCH;
        case (a)
            UA_FETCH: begin
                w.ctrl.pc_wr = 1'b1; w.ctrl.mem_rd = 1'b1; w.ctrl.ir_wr = 1'b1;
                w.ctrl.alu_b_sel = 2'b01; w.seq = SEQ_NEXT;
            end
            UA_DECODE: begin
                w.ctrl.alu_b_sel = 2'b11; w.ctrl.aluout_wr = 1'b1;
                w.seq = SEQ_DISP1;
            end
            UA_MEMADR: begin
                w.ctrl.alu_a_sel = 1'b1; w.ctrl.alu_b_sel = 2'b10;
                w.ctrl.aluout_wr = 1'b1; w.seq = SEQ_DISP2;
            end
            UA_LDRD: begin
                w.ctrl.mem_rd = 1'b1; w.ctrl.iord = 1'b1; w.ctrl.mdr_wr = 1'b1;
                w.seq = SEQ_NEXT;
            end
            UA_LDWB: begin
                w.ctrl.reg_wr = 1'b1; w.ctrl.mem_to_reg = 1'b1;
            end
            UA_STWR: begin
                w.ctrl.mem_wr = 1'b1; w.ctrl.iord = 1'b1;
            end
            UA_ALUEX: begin
                w.ctrl.alu_a_sel = 1'b1; w.ctrl.alu_op = 2'b10;
                w.ctrl.aluout_wr = 1'b1; w.seq = SEQ_NEXT;
            end
            UA_ALUWB: begin
                w.ctrl.reg_wr = 1'b1; w.ctrl.reg_dst = 1'b1;
            end
            UA_BR: begin
                w.ctrl.alu_a_sel = 1'b1; w.ctrl.alu_op = 2'b01;
                w.ctrl.pc_wr_cond = 1'b1; w.ctrl.pc_src = 2'b01;
            end
            UA_JMP: begin
                w.ctrl.pc_wr = 1'b1; w.ctrl.pc_src = 2'b10;
            end
            default: ;
        endcase
        return w;
    endfunction

    // Opcode-indexed lookup tables; table 0 after decode, table 1 after address calc.
    function automatic disp_t disp_lookup(int tbl, opcode_t op);
        disp_t d;
        d = '0;
        if (tbl == 0) begin
            case (op)
                OPC_ALU:        begin d.hit = 1'b1; d.target = UA_ALUEX;  end
                OPC_JMP:        begin d.hit = 1'b1; d.target = UA_JMP;    end
                OPC_BR:         begin d.hit = 1'b1; d.target = UA_BR;     end
                OPC_LD, OPC_ST: begin d.hit = 1'b1; d.target = UA_MEMADR; end
                default: ;
            endcase
        end else begin
            case (op)
                OPC_LD:  begin d.hit = 1'b1; d.target = UA_LDRD; end
                OPC_ST:  begin d.hit = 1'b1; d.target = UA_STWR; end
                default: ;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
#(
    parameter int WORDS = N_UWORDS
) (
    input  uaddr_t ua_i,
    output uword_t uw_o
);
    uword_t rom [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        assign rom[i] = ucode(uaddr_t'(i));
    end

    assign uw_o = rom[ua_i];

    // R8: no word asks the memory to read and write at once
    always_comb begin
        a_r8_mem_exclusive: assert (!(uw_o.ctrl.mem_rd && uw_o.ctrl.mem_wr));
    end
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
    import useq_pkg::*;
#(
    parameter int TABLES = N_TABLES
) (
    input  opcode_t                  opcode_i,
    output disp_t [TABLES-1:0]       tbl_o
);
    for (genvar t = 0; t < TABLES; t++) begin : g_tbl
        assign tbl_o[t] = disp_lookup(t, opcode_i);
    end
endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
#(
    parameter int TABLES = N_TABLES
) (
    input  uaddr_t               ua_i,
    input  seq_e                 seq_i,
    input  disp_t [TABLES-1:0]   tbl_i,
    output uaddr_t               ua_nxt_o,
    output logic                 miss_o
);
    always_comb begin
        ua_nxt_o = UA_FETCH;
        miss_o   = 1'b0;
        unique case (seq_i)
            SEQ_NEXT:  ua_nxt_o = ua_i + uaddr_t'(1);
            SEQ_DISP1: begin
                if (tbl_i[0].hit) ua_nxt_o = tbl_i[0].target;
                else              miss_o   = 1'b1;
            end
            SEQ_DISP2: begin
                if (tbl_i[1].hit) ua_nxt_o = tbl_i[1].target;
                else              miss_o   = 1'b1;
            end
            default:   ua_nxt_o = UA_FETCH;
        endcase
    end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OPC_W-1:0]  opcode_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [UA_W-1:0]   uaddr_o,
    output logic              illegal_o
);
    uaddr_t                ua_q;
    uaddr_t                ua_nxt;
    logic                  illegal_q;
    logic                  miss;
    uword_t                uw;
    disp_t [N_TABLES-1:0]  tbl;

    useq_store #(.WORDS(N_UWORDS)) u_store (
        .ua_i (ua_q),
        .uw_o (uw)
    );

    useq_dispatch #(.TABLES(N_TABLES)) u_disp (
        .opcode_i (opcode_i),
        .tbl_o    (tbl)
    );

    useq_next #(.TABLES(N_TABLES)) u_next (
        .ua_i     (ua_q),
        .seq_i    (uw.seq),
        .tbl_i    (tbl),
        .ua_nxt_o (ua_nxt),
        .miss_o   (miss)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ua_q      <= UA_FETCH;
            illegal_q <= 1'b0;
        end else begin
            ua_q <= ua_nxt;
            if (miss) illegal_q <= 1'b1;
        end
    end

    assign ctrl_o    = uw.ctrl;
    assign uaddr_o   = ua_q;
    assign illegal_o = illegal_q;

    // R3: increment code advances by one
    a_r3_increment: assert property (@(posedge clk) disable iff (rst)
        (uw.seq == SEQ_NEXT) |=> (ua_q == uaddr_t'($past(ua_q) + 4'd1)));

    // R4: fetch code returns to address 0
    a_r4_to_fetch: assert property (@(posedge clk) disable iff (rst)
        (uw.seq == SEQ_FETCH) |=> (ua_q == UA_FETCH));

    // R6: a hit in the second table lands on a load or store routine
    a_r6_disp2_target: assert property (@(posedge clk) disable iff (rst)
        (uw.seq == SEQ_DISP2 && !miss) |=> (ua_q == UA_LDRD || ua_q == UA_STWR));

    // R7: a miss goes to fetch and raises the flag
    a_r7_miss_fetch: assert property (@(posedge clk) disable iff (rst)
        miss |=> (ua_q == UA_FETCH && illegal_q));

    // R7: the flag holds until reset
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        illegal_q |=> illegal_q);

    // R8: instruction register written only in the fetch word
    a_r8_irwr_fetch: assert property (@(posedge clk) disable iff (rst)
        uw.ctrl.ir_wr |-> (ua_q == UA_FETCH));
endmodule

// File: tb/useq_ctrl_tb_top.sv
module useq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  opcode = 6'h00;
    logic [17:0] ctrl;
    logic [3:0]  uaddr;
    logic        illegal;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int exp_ua  = 0;
    bit exp_ill = 1'b0;
    string ua_tag;

    always #5 clk = ~clk;

    useq_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .opcode_i  (opcode),
        .ctrl_o    (ctrl),
        .uaddr_o   (uaddr),
        .illegal_o (illegal)
    );

    // R2: expected control bits per address
    function automatic logic [17:0] exp_ctrl(int a);
        logic [17:0] c = '0;
        case (a)
            0: begin c[17] = 1; c[14] = 1; c[12] = 1; c[6:5] = 2'b01; end
            1: begin c[6:5] = 2'b11; c[0] = 1; end
            2: begin c[4] = 1; c[6:5] = 2'b10; c[0] = 1; end
            3: begin c[14] = 1; c[15] = 1; c[1] = 1; end
            4: begin c[3] = 1; c[11] = 1; end
            5: begin c[13] = 1; c[15] = 1; end
            6: begin c[4] = 1; c[8:7] = 2'b10; c[0] = 1; end
            7: begin c[3] = 1; c[2] = 1; end
            8: begin c[4] = 1; c[8:7] = 2'b01; c[16] = 1; c[10:9] = 2'b01; end
            9: begin c[17] = 1; c[10:9] = 2'b10; end
            default: ;
        endcase
        return c;
    endfunction

    // R3 R4 R5 R6: next address; -1 marks a table miss (R7)
    function automatic int exp_next(int a, logic [5:0] op);
        case (a)
            0, 3, 6: return a + 1;
            1: case (op)
                   6'h00: return 6;
                   6'h02: return 9;
                   6'h04: return 8;
                   6'h23, 6'h2B: return 2;
                   default: return -1;
               endcase
            2: case (op)
                   6'h23: return 3;
                   6'h2B: return 5;
                   default: return -1;
               endcase
            default: return 0;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic check_all();
        check(ua_tag, 32'(uaddr), 32'(exp_ua));
        check("R7 flag", 32'(illegal), 32'(exp_ill));
        check("R2 ctrl", 32'(ctrl), 32'(exp_ctrl(exp_ua)));
        // R8: ir_wr only in fetch, no read/write conflict
        check("R8 ctrl", 32'((ctrl[12] && uaddr != 0) || (ctrl[14] && ctrl[13])), 32'd0);
    endtask

    // Drive at a falling edge, update the model at the rising edge, check at the next falling edge
    task automatic cycle(bit r, logic [5:0] op);
        int n;
        rst = r;
        opcode = op;
        @(posedge clk);
        if (r) begin
            exp_ua = 0; exp_ill = 1'b0; ua_tag = "R1 uaddr";
        end else begin
            n = exp_next(exp_ua, op);
            if (exp_ua == 1)      ua_tag = "R5 uaddr";
            else if (exp_ua == 2) ua_tag = "R6 uaddr";
            else if (exp_ua == 0 || exp_ua == 3 || exp_ua == 6) ua_tag = "R3/R9 uaddr";
            else                  ua_tag = "R4/R9 uaddr";
            if (n < 0) begin
                n = 0; exp_ill = 1'b1; ua_tag = "R7 uaddr";
            end
            exp_ua = n;
        end
        @(negedge clk);
        check_all();
    endtask

    // R10: run one instruction with a constant opcode and count cycles
    task automatic run_instr(logic [5:0] op, int expect_len);
        int len = 0;
        do begin
            cycle(1'b0, op);
            len++;
        end while (uaddr != 0 && len < 20);
        check("R10 length", 32'(len), 32'(expect_len));
    endtask

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        cycle(1'b1, 6'h00);
        cycle(1'b1, 6'h3F);
        // R1: reset state
        check("R1 reset uaddr", 32'(uaddr), 32'd0);
        check("R1 reset flag", 32'(illegal), 32'd0);

        run_instr(6'h00, 4);
        run_instr(6'h23, 5);
        run_instr(6'h2B, 4);
        run_instr(6'h04, 3);
        run_instr(6'h02, 3);

        // R7: illegal opcode at the first lookup
        cycle(1'b0, 6'h00);
        cycle(1'b0, 6'h3F);
        check("R7 miss1 flag", 32'(illegal), 32'd1);
        check("R7 miss1 uaddr", 32'(uaddr), 32'd0);
        run_instr(6'h00, 4);
        check("R7 sticky", 32'(illegal), 32'd1);
        // R1: reset clears the flag
        cycle(1'b1, 6'h00);
        check("R1 flag cleared", 32'(illegal), 32'd0);

        // R6 R7: load at first lookup, ALU opcode at second
        cycle(1'b0, 6'h23);
        cycle(1'b0, 6'h23);
        cycle(1'b0, 6'h00);
        check("R7 miss2 flag", 32'(illegal), 32'd1);
        check("R7 miss2 uaddr", 32'(uaddr), 32'd0);

        // Reset on the same edge as a miss
        cycle(1'b0, 6'h00);
        cycle(1'b1, 6'h3F);
        check("R1 reset over miss", 32'(illegal), 32'd0);

        // Random opcode every cycle, occasional reset
        for (int i = 0; i < 4000; i++) begin
            int sel = $urandom_range(0, 9);
            logic [5:0] op;
            case (sel)
                0: op = 6'h00;
                1: op = 6'h02;
                2: op = 6'h04;
                3, 4: op = 6'h23;
                5, 6: op = 6'h2B;
                default: op = 6'($urandom_range(0, 63));
            endcase
            cycle(($urandom_range(0, 299) == 0), op);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule